// File: doc/BRIEF.md
# Burst Transmit Framer with Payload Scrambler

This block shapes one transmit burst for a constant-envelope FSK-class modem. When a start request arrives, it waits for the next bit-rate strobe and sends a training header of programmable length. The header is made of bit pairs, 1,1,0,0 repeating, and begins with a 1. After the header it sends payload bits taken from a valid/ready serial stream. Each payload bit is XORed with the next bit of a 7-stage pseudo-random generator. This keeps the line data close to balanced and free of long constant runs and long single-bit alternations.

Every change on the line happens at a one-cycle bit-rate strobe. The transmit-enable output frames the burst. If the payload source falls behind, the framer sends scrambled fill bits and raises a sticky flag. A burst ends one bit period after the bit that carries the end-of-burst marker.

Top module: `burst_tx_framer`

## Requirements
- R1: The header length is the programmed `pre_len` captured when the burst begins. Any value below 16 is raised to 16, so the first payload bit goes out on strobe number max(pre_len,16)+1 of the burst.
- R2: Header bit k (counting from 0) is 1 when k mod 4 is 0 or 1, and 0 otherwise. The first bit is therefore 1, and the header never contains the run 1,0,1,0.
- R3: Each payload bit on the line equals the input bit XOR the generator output. The generator output is bit 6 of a 7-bit register. The register shifts toward bit 6, and bit 6 XOR bit 5 enters bit 0 (polynomial x^7+x^6+1).
- R4: The generator is loaded with 7'h7F when each burst begins. It advances once for every payload or fill bit and never for header bits.
- R5: `tx_bit` and `tx_en` change only in the clock cycle that follows a cycle in which `bit_stb` is high.
- R6: `in_ready` is high only in a cycle where `bit_stb` and `in_valid` are both high and a payload bit is due. A payload bit is consumed exactly in such a cycle.
- R7: `tx_en` rises together with the first header bit. It falls, with `tx_bit` returning to 0, at the first strobe after the bit that carried `in_last`.
- R8: If a payload bit is due while `in_valid` is low, the framer sends a 0 XOR the generator output and `underrun` goes high. `underrun` stays high until `tx_en` falls, and it is low at the start of the next burst.
- R9: A `start` seen while idle begins the burst at the next strobe, or at once if `bit_stb` is high in the same cycle. A `start` seen during a burst has no effect.
- R10: After reset, `tx_en`, `tx_bit`, `underrun` and `in_ready` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_stb | input | 1 | One-cycle bit-rate strobe |
| start | input | 1 | Burst start request |
| pre_len | input | LEN_W | Requested header length in bits |
| in_valid | input | 1 | Payload bit available |
| in_data | input | 1 | Payload bit |
| in_last | input | 1 | Marks the final payload bit of the burst |
| in_ready | output | 1 | Payload bit consumed this cycle |
| tx_bit | output | 1 | Serial line bit |
| tx_en | output | 1 | Transmit enable |
| underrun | output | 1 | Payload was missing at least once in this burst |

## Verification
The assertions are checked on every cycle. They cover the following: line outputs change only after a strobe, ready appears only on a strobe with valid data, the header never holds 1,0,1,0, and the header counter never passes the clamped length. They also check that the generator is reloaded with its seed, stays nonzero and holds still between advances, and that the underrun flag stays set for the rest of a burst. Some properties can only be shown by the bench's scenarios, which compare against a bit-exact model: the actual scrambled bit values, the exact header length for programmed values around and below 16, the fill bits sent during underrun, a start arriving together with a strobe, and a start ignored in the middle of a burst.

// File: rtl/btf_pkg.sv
package btf_pkg;

  localparam int LFSR_W = 7;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRE,
    ST_PAY,
    ST_TAIL
  } btf_state_e;

  // Header pattern: pairs of ones then pairs of zeros.
  function automatic logic pre_pattern(input int unsigned idx);
    return ((idx % 4) < 2);
  endfunction

  // One step of the x^7 + x^6 + 1 generator, output taken from the top stage.
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[LFSR_W-1] ^ s[LFSR_W-2]};
  endfunction

endpackage

// File: rtl/btf_preamble.sv
module btf_preamble #(
  parameter int LEN_W   = 8,
  parameter int MIN_LEN = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             adv,
  input  logic [LEN_W-1:0] len_req,
  output logic             pat_bit,
  output logic             done
);
  import btf_pkg::*;

  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);

  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] req);
    return (req < MIN_L) ? MIN_L : req;
  endfunction

  logic [LEN_W-1:0] eff_len;
  logic [LEN_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eff_len <= MIN_L;
      cnt     <= '0;
    end else if (load) begin
      eff_len <= clamp_len(len_req);
      cnt     <= LEN_W'(1);
    end else if (adv) begin
      cnt <= cnt + LEN_W'(1);
    end
  end

  assign pat_bit = load ? pre_pattern(0) : pre_pattern(32'(cnt));
  assign done    = (cnt >= eff_len);

  p_min_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cnt >= MIN_L));
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= eff_len);

endmodule

// File: rtl/btf_scrambler.sv
module btf_scrambler #(
  parameter logic [btf_pkg::LFSR_W-1:0] SEED = 7'h7F
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic adv,
  output logic key
);
  import btf_pkg::*;

  logic [LFSR_W-1:0] st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    st <= SEED;
    else if (load) st <= SEED;
    else if (adv)  st <= lfsr_step(st);
  end

  assign key = st[LFSR_W-1];

  p_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    st != '0);
  p_seed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load) |-> (st == SEED));
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load) && !$past(adv)) |-> $stable(st));

endmodule

// File: rtl/btf_seq.sv
module btf_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_stb,
  input  logic start,
  input  logic pre_done,
  input  logic pre_bit,
  input  logic key,
  input  logic in_valid,
  input  logic in_data,
  input  logic in_last,
  output logic in_ready,
  output logic begin_o,
  output logic pre_adv,
  output logic pay_adv,
  output logic tx_bit,
  output logic tx_en,
  output logic underrun
);
  import btf_pkg::*;

  btf_state_e state;
  logic       start_pend;
  logic [3:0] pre_hist;   // last header bits, for the pattern check

  logic pay_due, take, tail_w, pay_bit;

  assign begin_o  = (state == ST_IDLE) && bit_stb && (start || start_pend);
  assign pre_adv  = (state == ST_PRE) && bit_stb && !pre_done;
  assign pay_due  = bit_stb && (((state == ST_PRE) && pre_done) || (state == ST_PAY));
  assign take     = pay_due && in_valid;
  assign tail_w   = (state == ST_TAIL) && bit_stb;
  assign in_ready = take;
  assign pay_adv  = pay_due;
  assign pay_bit  = (in_valid & in_data) ^ key;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      start_pend <= 1'b0;
      tx_bit     <= 1'b0;
      tx_en      <= 1'b0;
      underrun   <= 1'b0;
      pre_hist   <= 4'b0000;
    end else begin
      if (state == ST_IDLE && start && !bit_stb) start_pend <= 1'b1;
      if (begin_o) begin
        state      <= ST_PRE;
        start_pend <= 1'b0;
        tx_en      <= 1'b1;
        tx_bit     <= pre_bit;
        underrun   <= 1'b0;
        pre_hist   <= {3'b000, pre_bit};
      end else if (pre_adv) begin
        tx_bit   <= pre_bit;
        pre_hist <= {pre_hist[2:0], pre_bit};
      end else if (pay_due) begin
        tx_bit <= pay_bit;
        if (!in_valid) underrun <= 1'b1;
        state <= (take && in_last) ? ST_TAIL : ST_PAY;
      end else if (tail_w) begin
        state    <= ST_IDLE;
        tx_en    <= 1'b0;
        tx_bit   <= 1'b0;
        underrun <= 1'b0;
      end
    end
  end

  p_stb_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bit_stb) |-> ($stable(tx_bit) && $stable(tx_en)));
  p_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (bit_stb && in_valid && (state == ST_PRE || state == ST_PAY)));
  p_no_1010_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PRE) |-> (pre_hist != 4'b1010));
  p_first_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> tx_bit);
  p_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> ($past(state) == ST_IDLE));
  p_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_en) |-> ($past(state) == ST_TAIL));
  p_ur_inside_r8: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> tx_en);
  p_ur_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(underrun) && tx_en) |-> underrun);
  p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |-> !start_pend);

endmodule

// File: rtl/burst_tx_framer.sv
module burst_tx_framer #(
  parameter int                          LEN_W   = 8,
  parameter int                          MIN_PRE = 16,
  parameter logic [btf_pkg::LFSR_W-1:0]  SEED    = 7'h7F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_stb,
  input  logic             start,
  input  logic [LEN_W-1:0] pre_len,
  input  logic             in_valid,
  input  logic             in_data,
  input  logic             in_last,
  output logic             in_ready,
  output logic             tx_bit,
  output logic             tx_en,
  output logic             underrun
);

  logic begin_w, pre_adv_w, pay_adv_w, pre_done_w, pre_bit_w, key_w;

  btf_preamble #(.LEN_W(LEN_W), .MIN_LEN(MIN_PRE)) u_pre (
    .clk(clk), .rst_n(rst_n), .load(begin_w), .adv(pre_adv_w),
    .len_req(pre_len), .pat_bit(pre_bit_w), .done(pre_done_w)
  );

  btf_scrambler #(.SEED(SEED)) u_scr (
    .clk(clk), .rst_n(rst_n), .load(begin_w), .adv(pay_adv_w), .key(key_w)
  );

  btf_seq u_seq (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .start(start),
    .pre_done(pre_done_w), .pre_bit(pre_bit_w), .key(key_w),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_ready(in_ready), .begin_o(begin_w), .pre_adv(pre_adv_w),
    .pay_adv(pay_adv_w), .tx_bit(tx_bit), .tx_en(tx_en), .underrun(underrun)
  );

  p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(pre_adv_w && pay_adv_w));

endmodule

// File: tb/burst_tx_framer_tb.sv
module burst_tx_framer_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_stb = 1'b0, start = 1'b0;
  logic [7:0] pre_len = 8'd0;
  logic       in_valid = 1'b0, in_data = 1'b0, in_last = 1'b0;
  logic       in_ready, tx_bit, tx_en, underrun;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  burst_tx_framer u_dut (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .start(start), .pre_len(pre_len),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_ready(in_ready), .tx_bit(tx_bit), .tx_en(tx_en), .underrun(underrun)
  );

  function automatic bit exp_pre(input int k);
    bit [3:0] lut = 4'b0011;   // entries for k mod 4 = 3,2,1,0
    return lut[k % 4];
  endfunction

  function automatic bit [6:0] exp_next(input bit [6:0] s);
    bit fb = s[6] ^ s[5];
    return (s << 1) | {6'd0, fb};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // One strobe: drive at a falling edge, check ready before the rising edge,
  // check registered outputs after it, then hold idle and check stability.
  task automatic strobe(input bit v, input bit d, input bit l, input bit st,
                        input bit e_rdy, input bit e_en, input bit e_bit,
                        input bit e_ur, input string tag);
    int gap;
    @(negedge clk);
    bit_stb = 1'b1; in_valid = v; in_data = d; in_last = l; start = st;
    #1 chk({tag, " R6 ready"}, in_ready, e_rdy);
    @(negedge clk);
    bit_stb = 1'b0; start = 1'b0; in_valid = 1'b0; in_last = 1'b0;
    chk({tag, " R7 tx_en"}, tx_en, e_en);
    chk({tag, " tx_bit"}, tx_bit, e_bit);
    chk({tag, " R8 underrun"}, underrun, e_ur);
    gap = $urandom_range(0, 2);
    if (gap > 0) begin
      repeat (gap) @(negedge clk);
      chk({tag, " R5 stable"}, {tx_en, tx_bit}, {e_en, e_bit});
    end
  endtask

  task automatic run_burst(input int len_prog, input int nbits, input int miss_pct,
                           input bit same_cycle, input bit mid_start);
    int eff;
    int j;
    bit [6:0] lf;
    bit ur;
    eff = (len_prog < 16) ? 16 : len_prog;
    pre_len = 8'(len_prog);
    lf = 7'h7F;
    ur = 1'b0;
    if (!same_cycle) begin
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk("R9 wait for strobe", tx_en, 0);
    end
    for (int k = 0; k < eff; k++) begin
      // valid held high: ready must stay low for the whole header (R1, R6)
      strobe(1'b1, 1'($urandom_range(0, 1)), 1'b0,
             (k == 0 && same_cycle) || (k == 5 && mid_start),
             1'b0, 1'b1, exp_pre(k), 1'b0, "R1 R2 header");
      if (k == 7) pre_len = 8'd200;  // change after capture must not matter (R1)
    end
    j = 0;
    while (j < nbits) begin
      bit v, d, l;
      v = ($urandom_range(0, 99) >= miss_pct);
      d = 1'($urandom_range(0, 1));
      l = (j == nbits - 1);
      if (!v) ur = 1'b1;
      strobe(v, d, l, 1'b0, v, 1'b1, (v & d) ^ lf[6], ur, "R3 R4 payload");
      lf = exp_next(lf);
      if (v) j++;
    end
    strobe(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R7 R8 end");
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R10 tx_en", tx_en, 0);
    chk("R10 tx_bit", tx_bit, 0);
    chk("R10 underrun", underrun, 0);
    chk("R10 in_ready", in_ready, 0);
    rst_n = 1'b1;
    // strobes without a start leave the line idle
    for (int i = 0; i < 3; i++)
      strobe(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R9 idle");
    run_burst(0, 24, 0, 1'b0, 1'b0);    // clamp from 0
    run_burst(15, 30, 0, 1'b0, 1'b0);   // clamp edge
    run_burst(16, 20, 0, 1'b1, 1'b0);   // exact minimum, start with strobe
    run_burst(17, 33, 0, 1'b0, 1'b1);   // start mid-burst ignored
    run_burst(40, 50, 25, 1'b0, 1'b0);  // underrun gaps
    run_burst(20, 1, 0, 1'b0, 1'b0);    // single payload bit
    run_burst(255, 60, 10, 1'b1, 1'b0); // longest header
    for (int b = 0; b < 6; b++)
      run_burst($urandom_range(0, 64), $urandom_range(1, 80),
                $urandom_range(0, 30), 1'($urandom_range(0, 1)),
                1'($urandom_range(0, 1)));
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule